// File: doc/BRIEF.md
# DMA Channel Command and Status Unit

This block is the control side of one DMA channel. Software writes one-hot command words through a register write port. The unit turns each write into a single channel operation and keeps a five-state channel state machine: idle, running, paused, stopped and disabled. The data mover is not part of this block. It is represented by a pulse that marks a finished transfer, a pulse that marks a bus error, and a three-bit error cause that comes with the error pulse.

The unit keeps two sets of bits. Sticky state bits record how the last transfer ended. Interrupt flags are cleared by writing a one to them, and each flag is gated by an interrupt-enable bit before it reaches the level interrupt output. The unit also stores the cause of the last bus error and holds one configuration word that a clear command returns to its reset value. While the channel is paused, a completion or error from the mover is held and only takes effect on resume. Reads are combinational from the register select.

Top module: `dmach_ctrl`

## Requirements
- R1: Command word bits are bit0 enable, bit1 clear, bit2 disable, bit3 stop, bit4 pause and bit5 resume. When several bits are set in one write, only the highest-ranked one acts. The ranking from highest to lowest is clear, stop, disable, pause, resume, enable.
- R2: Enable moves the channel from idle, stopped or disabled to running and clears the sticky state bits. Enable is ignored while the channel is running or paused.
- R3: Pause acts only while running and moves the channel to paused, shown by status bit 20. Resume acts only while paused and returns the channel to running. `chan_run` is high exactly in the running state.
- R4: Stop or disable, issued while running or paused, moves the channel to stopped (status bit 19) or disabled (status bit 18). Neither raises a completion flag, and both discard any held event. Both are ignored in other states.
- R5: A completion pulse while running moves the channel to idle and sets state bit 16 and flag bit 0. An error pulse while running sets state bit 17 and flag bit 1 instead. If both pulses arrive together, the error wins.
- R6: Completion or error pulses that arrive while paused, or in the same cycle as an accepted pause, are held. Status bit 21 is set while an event is held. A later resume applies the held event in that cycle.
- R7: When an error is applied, the error-info register stores cause bit 2 (read poison) at bit 18, cause bit 1 (write response) at bit 17 and cause bit 0 (read response) at bit 16.
- R8: `irq` is high while flag bit 0 is set with enable bit 0, or flag bit 1 is set with enable bit 1.
- R9: A status write clears each flag whose data bit is one. A flag set by an event in the same cycle stays set. The state bits are not changed by the write.
- R10: Clear moves the channel to idle and sets the configuration word to `CFG_RESET`. It zeroes the interrupt enables, flags, sticky bits and error info.
- R11: Completion and error pulses have no effect while the channel is idle, stopped or disabled.
- R12: The register selects are: 0 command, 1 status, 2 interrupt enable, 3 configuration, 4 error info. Reading the command select returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 32 | Read data, combinational |
| xfer_done | input | 1 | Transfer-complete pulse from the mover |
| xfer_err | input | 1 | Bus-error pulse from the mover |
| xfer_err_cause | input | 3 | Error cause that comes with `xfer_err` |
| chan_run | output | 1 | Channel is in the running state |
| cfg_o | output | 32 | Current configuration word |
| irq | output | 1 | Level interrupt |

## Verification
The case that needs the most care is a software command and a mover event landing in the same cycle. The bench provokes this with pause plus completion, stop plus completion, and a flag-clearing status write plus a new completion. It judges each case from the status word in the next cycle:
- pause plus completion must leave the event held, with bit 21 set;
- stop plus completion must end in the stopped state with no completion flag;
- the status write plus a new completion must leave the flag set.

Alongside these, the bench sweeps every 6-bit command word from each of the five states and compares the resulting state with a priority model.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_PAUSE = 3'd2,
        ST_STOP  = 3'd3,
        ST_DIS   = 3'd4
    } chan_st_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_CLEAR   = 3'd1,
        OP_STOP    = 3'd2,
        OP_DISABLE = 3'd3,
        OP_PAUSE   = 3'd4,
        OP_RESUME  = 3'd5,
        OP_ENABLE  = 3'd6
    } chan_op_e;

    typedef enum logic [2:0] {
        SEL_CMD  = 3'd0,
        SEL_STAT = 3'd1,
        SEL_IEN  = 3'd2,
        SEL_CFG  = 3'd3,
        SEL_ERR  = 3'd4
    } reg_sel_e;

    localparam int CMD_BITS   = 6;
    localparam int FLAG_BITS  = 2;
    localparam int CAUSE_BITS = 3;
    localparam int STICKY_LSB = 16;
    localparam int ERR_LSB    = 16;

    typedef struct packed {
        logic                  done;
        logic                  err;
        logic [CAUSE_BITS-1:0] cause;
    } evt_t;

    typedef struct packed {
        logic clr;
        logic start;
        logic stop;
        logic dis;
    } ctl_t;

    // Command bit index for a given rank (rank 0 is the highest priority).
    function automatic int rank_bit(input int rank);
        case (rank)
            0:       return 1;
            1:       return 3;
            2:       return 2;
            3:       return 4;
            4:       return 5;
            default: return 0;
        endcase
    endfunction

    function automatic chan_op_e bit_op(input int b);
        case (b)
            0:       return OP_ENABLE;
            1:       return OP_CLEAR;
            2:       return OP_DISABLE;
            3:       return OP_STOP;
            4:       return OP_PAUSE;
            default: return OP_RESUME;
        endcase
    endfunction

    function automatic logic is_active(input chan_st_e s);
        return (s == ST_RUN) || (s == ST_PAUSE);
    endfunction

endpackage

// File: rtl/dmach_cmd_decode.sv
module dmach_cmd_decode
    import dmach_pkg::*;
(
    input  logic                cmd_wr,
    input  logic [CMD_BITS-1:0] cmd_word,
    output chan_op_e            op_o
);
    // Walk from the lowest rank to the highest so that a higher rank overrides.
    always_comb begin
        op_o = OP_NONE;
        if (cmd_wr) begin
            for (int r = CMD_BITS - 1; r >= 0; r--) begin
                if (cmd_word[rank_bit(r)]) op_o = bit_op(rank_bit(r));
            end
        end
    end
endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm
    import dmach_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  chan_op_e              op_i,
    input  logic                  done_i,
    input  logic                  err_i,
    input  logic [CAUSE_BITS-1:0] cause_i,
    output chan_st_e              st_o,
    output evt_t                  ev_o,
    output ctl_t                  ctl_o,
    output logic                  hold_o
);
    chan_st_e st_q, st_n;
    evt_t     pend_q, pend_n, ev_in;
    logic     act, run_after;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pend_q <= '0;
        end else begin
            st_q   <= st_n;
            pend_q <= pend_n;
        end
    end

    always_comb begin
        act         = is_active(st_q);
        ev_in.done  = act && (pend_q.done || done_i);
        ev_in.err   = act && (pend_q.err || err_i);
        ev_in.cause = pend_q.err ? pend_q.cause : cause_i;
        run_after   = ((st_q == ST_RUN) && (op_i != OP_PAUSE)) ||
                      ((st_q == ST_PAUSE) && (op_i == OP_RESUME));
        st_n   = st_q;
        pend_n = pend_q;
        ev_o   = '0;
        ctl_o  = '0;
        if (op_i == OP_CLEAR) begin
            ctl_o.clr = 1'b1;
            st_n      = ST_IDLE;
            pend_n    = '0;
        end else if (act && (op_i == OP_STOP || op_i == OP_DISABLE)) begin
            ctl_o.stop = (op_i == OP_STOP);
            ctl_o.dis  = (op_i == OP_DISABLE);
            st_n       = (op_i == OP_STOP) ? ST_STOP : ST_DIS;
            pend_n     = '0;
        end else if (!act && op_i == OP_ENABLE) begin
            ctl_o.start = 1'b1;
            st_n        = ST_RUN;
        end else if (act) begin
            if (run_after && (ev_in.done || ev_in.err)) begin
                ev_o.err   = ev_in.err;
                ev_o.done  = ev_in.done && !ev_in.err;
                ev_o.cause = ev_in.err ? ev_in.cause : '0;
                st_n       = ST_IDLE;
                pend_n     = '0;
            end else if (run_after) begin
                st_n = ST_RUN;
            end else begin
                st_n   = ST_PAUSE;
                pend_n = ev_in;
            end
        end
    end

    assign st_o   = st_q;
    assign hold_o = (st_q == ST_PAUSE) && (pend_q.done || pend_q.err);

    assert_pause_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PAUSE && op_i == OP_NONE) |=> (st_q == ST_PAUSE));

    assert_resume_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_RESUME && !is_active(st_q)) |=> $stable(st_q));

    assert_clear_to_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CLEAR) |=> (st_q == ST_IDLE));

    assert_idle_ignores_events_R11: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && op_i == OP_NONE) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int              CFG_W     = 32,
    parameter logic [CFG_W-1:0] CFG_RESET = '0
)(
    input  logic                  clk,
    input  logic                  rst,
    input  evt_t                  ev_i,
    input  ctl_t                  ctl_i,
    input  logic                  wr_stat,
    input  logic                  wr_ien,
    input  logic                  wr_cfg,
    input  logic [CFG_W-1:0]      wdata,
    output logic [FLAG_BITS-1:0]  flag_o,
    output logic [FLAG_BITS-1:0]  ien_o,
    output logic [3:0]            sticky_o,
    output logic [CAUSE_BITS-1:0] cause_o,
    output logic [CFG_W-1:0]      cfg_o
);
    logic [FLAG_BITS-1:0]  flag_q, w1c;
    logic [FLAG_BITS-1:0]  ien_q;
    logic [3:0]            sticky_q;
    logic [CAUSE_BITS-1:0] cause_q;
    logic [CFG_W-1:0]      cfg_q;

    assign w1c = wr_stat ? wdata[FLAG_BITS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst || ctl_i.clr) begin
            flag_q   <= '0;
            ien_q    <= '0;
            sticky_q <= '0;
            cause_q  <= '0;
            cfg_q    <= CFG_RESET;
        end else begin
            flag_q <= (flag_q & ~w1c) | {ev_i.err, ev_i.done};
            if (ctl_i.start) sticky_q <= '0;
            else sticky_q <= sticky_q | {ctl_i.stop, ctl_i.dis, ev_i.err, ev_i.done};
            if (ev_i.err) cause_q <= ev_i.cause;
            if (wr_ien) ien_q <= wdata[FLAG_BITS-1:0];
            if (wr_cfg) cfg_q <= wdata;
        end
    end

    assign flag_o   = flag_q;
    assign ien_o    = ien_q;
    assign sticky_o = sticky_q;
    assign cause_o  = cause_q;
    assign cfg_o    = cfg_q;

    assert_stop_no_done_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.stop || ctl_i.dis) |=> !$rose(flag_q[0]));

    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wdata[0] && !ev_i.done) |=> !flag_q[0]);

    assert_clear_defaults_R10: assert property (@(posedge clk) disable iff (rst)
        ctl_i.clr |=> (cfg_q == CFG_RESET && ien_q == '0 && cause_q == '0));
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
    import dmach_pkg::*;
#(
    parameter logic [31:0] CFG_RESET = 32'h0000_0A05
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_sel,
    output logic [31:0] rd_data,
    input  logic        xfer_done,
    input  logic        xfer_err,
    input  logic [2:0]  xfer_err_cause,
    output logic        chan_run,
    output logic [31:0] cfg_o,
    output logic        irq
);
    localparam int DW = 32;

    chan_op_e              op;
    chan_st_e              st;
    evt_t                  ev;
    ctl_t                  ctl;
    logic                  hold;
    logic [FLAG_BITS-1:0]  flags, ien;
    logic [3:0]            sticky;
    logic [CAUSE_BITS-1:0] cause;
    logic [DW-1:0]         stat_word;
    reg_sel_e              wsel, rsel;

    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    dmach_cmd_decode u_dec (
        .cmd_wr   (wr_en && wsel == SEL_CMD),
        .cmd_word (wr_data[CMD_BITS-1:0]),
        .op_o     (op)
    );

    dmach_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .done_i  (xfer_done),
        .err_i   (xfer_err),
        .cause_i (xfer_err_cause),
        .st_o    (st),
        .ev_o    (ev),
        .ctl_o   (ctl),
        .hold_o  (hold)
    );

    dmach_regs #(.CFG_W(DW), .CFG_RESET(CFG_RESET)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .ev_i     (ev),
        .ctl_i    (ctl),
        .wr_stat  (wr_en && wsel == SEL_STAT),
        .wr_ien   (wr_en && wsel == SEL_IEN),
        .wr_cfg   (wr_en && wsel == SEL_CFG),
        .wdata    (wr_data),
        .flag_o   (flags),
        .ien_o    (ien),
        .sticky_o (sticky),
        .cause_o  (cause),
        .cfg_o    (cfg_o)
    );

    always_comb begin
        stat_word = '0;
        stat_word[FLAG_BITS-1:0]             = flags;
        stat_word[STICKY_LSB +: 4]           = sticky;
        stat_word[STICKY_LSB + 4]            = (st == ST_PAUSE);
        stat_word[STICKY_LSB + 5]            = hold;
    end

    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_STAT: rd_data = stat_word;
            SEL_IEN:  rd_data[FLAG_BITS-1:0] = ien;
            SEL_CFG:  rd_data = cfg_o;
            SEL_ERR:  rd_data[ERR_LSB +: CAUSE_BITS] = cause;
            default:  rd_data = '0;
        endcase
    end

    assign chan_run = (st == ST_RUN);
    assign irq      = |(flags & ien);

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq);

    assert_hold_only_paused_R6: assert property (@(posedge clk) disable iff (rst)
        hold |-> !chan_run);
endmodule

// File: tb/dmach_ctrl_tb.sv
module dmach_ctrl_tb;
    localparam logic [31:0] CFG_DEF = 32'h0000_0A05;
    localparam logic [31:0] C_EN = 32'h01, C_CLR = 32'h02, C_DIS = 32'h04,
                            C_STP = 32'h08, C_PAU = 32'h10, C_RES = 32'h20;
    localparam int S_IDLE = 0, S_RUN = 1, S_PAUSE = 2, S_STOP = 3, S_DIS = 4;

    logic        clk = 0, rst = 1;
    logic        wr_en = 0;
    logic [2:0]  wr_sel = 0, rd_sel = 0, cause_i = 0;
    logic [31:0] wr_data = 0, rd_data, cfg_o;
    logic        done_i = 0, err_i = 0, chan_run, irq;
    int          checks = 0, errors = 0, cycles = 0;
    logic [31:0] v;

    always #10 clk = ~clk;

    dmach_ctrl #(.CFG_RESET(CFG_DEF)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .xfer_done(done_i), .xfer_err(err_i),
        .xfer_err_cause(cause_i), .chan_run(chan_run), .cfg_o(cfg_o), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act timeout exp finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step(input logic [2:0] sel, input logic w, input logic [31:0] d,
                        input logic ed, input logic ee, input logic [2:0] ec);
        @(negedge clk);
        wr_en = w; wr_sel = sel; wr_data = d; done_i = ed; err_i = ee; cause_i = ec;
        @(negedge clk);
        wr_en = 0; done_i = 0; err_i = 0; cause_i = 0; wr_data = 0;
    endtask

    task automatic cmd(input logic [31:0] d);
        step(3'd0, 1'b1, d, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        rd_sel = sel; #1; d = rd_data;
    endtask

    task automatic go(input int s);
        cmd(C_CLR);
        if (s != S_IDLE) cmd(C_EN);
        if (s == S_PAUSE) cmd(C_PAU);
        if (s == S_STOP)  cmd(C_STP);
        if (s == S_DIS)   cmd(C_DIS);
    endtask

    function automatic int model(input int s, input logic [5:0] w);
        int b = -1;
        // priority clear, stop, disable, pause, resume, enable (R1)
        if (w[1]) b = 1; else if (w[3]) b = 3; else if (w[2]) b = 2;
        else if (w[4]) b = 4; else if (w[5]) b = 5; else if (w[0]) b = 0;
        case (b)
            1: return S_IDLE;
            3: return (s == S_RUN || s == S_PAUSE) ? S_STOP : s;
            2: return (s == S_RUN || s == S_PAUSE) ? S_DIS : s;
            4: return (s == S_RUN) ? S_PAUSE : s;
            5: return (s == S_PAUSE) ? S_RUN : s;
            0: return (s == S_RUN || s == S_PAUSE) ? s : S_RUN;
            default: return s;
        endcase
    endfunction

    function automatic int observe(input logic [31:0] st, input logic run);
        if (run) return S_RUN;
        if (st[20]) return S_PAUSE;
        if (st[19]) return S_STOP;
        if (st[18]) return S_DIS;
        return S_IDLE;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        rd(3'd1, v); chk("R12 reset status", v, 0);
        chk("R8 reset irq", {31'b0, irq}, 0);
        chk("R3 reset run", {31'b0, chan_run}, 0);
        rd(3'd3, v); chk("R10 reset cfg", v, CFG_DEF);

        // sweep every command word from every state: R1 R2 R3 R4
        for (int s = 0; s < 5; s++) begin
            for (int w = 0; w < 64; w++) begin
                go(s);
                cmd(w);
                rd(3'd1, v);
                chk($sformatf("R1 sweep st%0d w%0h", s, w), observe(v, chan_run), model(s, w[5:0]));
            end
        end

        // R3 resume returns to running
        go(S_PAUSE); cmd(C_RES);
        chk("R3 resume run", {31'b0, chan_run}, 1);

        // R5 completion, R8 gating, R9 clear
        go(S_RUN); step(3'd0, 0, 0, 1, 0, 0);
        rd(3'd1, v); chk("R5 done status", v, (1 << 16) | 1);
        chk("R8 irq masked", {31'b0, irq}, 0);
        step(3'd2, 1, 1, 0, 0, 0);
        chk("R8 irq enabled", {31'b0, irq}, 1);
        step(3'd1, 1, 1, 0, 0, 0);
        rd(3'd1, v); chk("R9 w1c flag", v, 1 << 16);
        chk("R8 irq after w1c", {31'b0, irq}, 0);

        // R5 R7 error capture
        go(S_RUN); step(3'd2, 1, 3, 0, 0, 0);
        step(3'd0, 0, 0, 0, 1, 3'b101);
        rd(3'd1, v); chk("R5 error status", v, (1 << 17) | 2);
        rd(3'd4, v); chk("R7 error info", v, 32'b101 << 16);
        chk("R8 irq error", {31'b0, irq}, 1);

        // R5 both pulses: error wins
        go(S_RUN); step(3'd0, 0, 0, 1, 1, 3'b010);
        rd(3'd1, v); chk("R5 error wins", v, (1 << 17) | 2);
        rd(3'd4, v); chk("R7 write cause", v, 32'b010 << 16);

        // R6 held while paused
        go(S_PAUSE); step(3'd0, 0, 0, 1, 0, 0);
        rd(3'd1, v); chk("R6 held", v, (1 << 20) | (1 << 21));
        cmd(C_RES);
        rd(3'd1, v); chk("R6 resume applies", v, (1 << 16) | 1);
        chk("R6 run after apply", {31'b0, chan_run}, 0);

        // R6 pause and completion in one cycle, then R4 stop discards it
        go(S_RUN); step(3'd0, 1, C_PAU, 1, 0, 0);
        rd(3'd1, v); chk("R6 pause same cycle", v, (1 << 20) | (1 << 21));
        cmd(C_STP);
        rd(3'd1, v); chk("R4 stop discards held", v, 1 << 19);

        // R4 stop and completion in one cycle
        go(S_RUN); step(3'd0, 1, C_STP, 1, 0, 0);
        rd(3'd1, v); chk("R4 stop beats done", v, 1 << 19);

        // R9 w1c with new event, R2 sticky cleared on enable
        go(S_RUN); step(3'd0, 0, 0, 1, 0, 0);
        cmd(C_EN);
        rd(3'd1, v); chk("R2 enable clears sticky", v, 1);
        step(3'd1, 1, 1, 1, 0, 0);
        rd(3'd1, v); chk("R9 set wins over w1c", v, (1 << 16) | 1);

        // R11 ignored events
        go(S_IDLE); step(3'd0, 0, 0, 1, 1, 3'b111);
        rd(3'd1, v); chk("R11 idle ignores", v, 0);
        go(S_STOP); step(3'd0, 0, 0, 0, 1, 3'b111);
        rd(3'd1, v); chk("R11 stopped ignores", v, 1 << 19);
        rd(3'd4, v); chk("R11 no cause", v, 0);

        // R12 R10 register access and clear
        step(3'd3, 1, 32'hDEADBEEF, 0, 0, 0);
        rd(3'd3, v); chk("R12 cfg write", v, 32'hDEADBEEF);
        chk("R12 cfg port", cfg_o, 32'hDEADBEEF);
        step(3'd2, 1, 3, 0, 0, 0);
        rd(3'd0, v); chk("R12 cmd reads zero", v, 0);
        cmd(C_CLR);
        rd(3'd3, v); chk("R10 cfg default", v, CFG_DEF);
        rd(3'd2, v); chk("R10 ien zero", v, 0);
        rd(3'd1, v); chk("R10 status zero", v, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule